// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler

This block is an 8-bit count register that software loads and reads. It advances either once per instruction cycle or on a chosen edge of an external pin. An 8-bit ripple prescaler can be placed in front of the count or behind a free-running watchdog tick. Whichever path does not own the prescaler runs undivided.

A wrap from all ones to zero raises a sticky overflow flag. An enable bit gates that flag onto the interrupt request. Loading the count stalls counting for two instruction cycles. A sleep input freezes the count, but the watchdog keeps running.

The block has no streaming data path. The register port is a single-cycle write strobe with no back-pressure, and all other pins are plain control and status lines.

Top module: `tick_timer`

## Requirements
- R1: While reset is low, the count, the overflow flag, the interrupt request and the watchdog time-out are all 0.
- R2: With cfg[5]=0 and cfg[3]=1, the count rises by exactly 1 at each clock edge where cyc_en is 1. The value of cfg[2:0] has no effect in this setting, and edges with cyc_en=0 leave the count unchanged.
- R3: A clock edge with wr_en=1 loads wr_data into the count. The next two edges with cyc_en=1 do not advance it.
- R4: An advance from 8'hFF gives 8'h00 and sets ovf_flag. If flag_clr arrives in that same cycle, the set wins.
- R5: Once set, ovf_flag stays at 1 until a clock edge with flag_clr=1 and no wrap, which returns it to 0.
- R6: irq equals ovf_flag AND irq_en. ovf_flag still sets while irq_en is 0.
- R7: With cfg[5]=1, the count advances on pin edges and ignores cyc_en. cfg[4]=0 selects rising edges and cfg[4]=1 selects falling edges; edges of the other polarity have no effect. The count changes at the third clock edge after the pin changes. High and low levels of two clocks each are all counted.
- R8: With cfg[3]=0, the count advances once every 2^(cfg[2:0]+1) source events. A write clears the prescaler, so the first advance after a write comes at the (2 + 2^(cfg[2:0]+1))th cycle-enabled edge.
- R9: wdt_timeout is a one-cycle pulse. Pulses are 2^WDOG_W cyc_en cycles apart when cfg[3]=0, and 2^(WDOG_W+cfg[2:0]) apart when cfg[3]=1.
- R10: While sleep is 1, the count does not advance, a write still loads it, and the watchdog keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable |
| wr_en | input | 1 | Count register write strobe |
| wr_data | input | CNT_W | Value to load into the count |
| cfg | input | 6 | [5] source, [4] edge, [3] prescaler owner, [2:0] tap |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the overflow flag |
| ext_pin | input | 1 | External count pin, asynchronous |
| sleep | input | 1 | Freezes the count while high |
| count | output | CNT_W | Current count value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |
| wdt_timeout | output | 1 | Watchdog time-out pulse |

## Verification
The bench builds the block with WDOG_W=4, so the undivided watchdog fires every 16 cycles and the 1:4 prescaled watchdog fires every 64 cycles; both intervals can be measured within a short run. CNT_W and the prescaler width keep their defaults, which puts the full 1:256 timer tap and the 8'hFF wrap, including the tie between a wrap and a flag clear, within reach of directed tests.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int TAP_W = 3;
  localparam int PRE_W = 1 << TAP_W;
  localparam int CFG_W = TAP_W + 3;

  typedef struct packed {
    logic             src_ext;
    logic             edge_fall;
    logic             pre_to_wdog;
    logic [TAP_W-1:0] tap;
  } tmr_cfg_t;
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  // sh[STAGES-1] is the synchronized level, sh[STAGES] the previous one
  assign evt = fall_sel ? (~sh[STAGES-1] &  sh[STAGES])
                        : ( sh[STAGES-1] & ~sh[STAGES]);
endmodule

// File: rtl/tick_prescale.sv
module tick_prescale
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  input  logic [TAP_W-1:0] sel,
  input  logic             wdog_map,
  output logic             carry
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W:0]   tap_ok;
  logic [TAP_W:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre <= '0;
    else if (clr) pre <= '0;
    else if (evt) pre <= pre + 1'b1;
  end

  // tap_ok[g] is high when the low g bits of the counter are all ones
  for (genvar g = 0; g <= PRE_W; g++) begin : g_tap
    if (g == 0) begin : g_zero
      assign tap_ok[g] = 1'b1;
    end else begin : g_bits
      assign tap_ok[g] = &pre[g-1:0];
    end
  end

  assign idx   = wdog_map ? {1'b0, sel} : ({1'b0, sel} + (TAP_W+1)'(1));
  assign carry = evt & tap_ok[idx];
endmodule

// File: rtl/tick_wdog.sv
module tick_wdog #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  output logic base_tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cyc_en) cnt <= cnt + 1'b1;
  end

  assign base_tick = cyc_en & (&cnt);
endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             evt_raw,
  input  logic             sleep,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             use_pre,
  input  logic             pre_carry,
  input  logic             flag_clr,
  output logic             path_evt,
  output logic             step,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag
);
  localparam int INH_CYC = 2;
  localparam int INH_W   = $clog2(INH_CYC + 1);

  logic [INH_W-1:0] inhib;
  logic             wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          inhib <= '0;
    else if (wr_en)                      inhib <= INH_W'(INH_CYC);
    else if (cyc_en && (inhib != '0))    inhib <= inhib - 1'b1;
  end

  assign path_evt = evt_raw & ~sleep & (inhib == '0) & ~wr_en;
  assign step     = use_pre ? pre_carry : path_evt;
  assign wrap     = step & (&count) & ~wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (wr_en) count <= wr_data;
    else if (step)  count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap)     ovf_flag <= 1'b1;
    else if (flag_clr) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WDOG_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CFG_W-1:0] cfg,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             ext_pin,
  input  logic             sleep,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wdt_timeout
);
  tmr_cfg_t c;
  logic ext_evt, evt_raw, path_evt, cnt_step;
  logic base_tick, pre_evt, pre_clr, pre_carry;

  assign c = tmr_cfg_t'(cfg);

  tick_sync #(.STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .fall_sel(c.edge_fall), .evt(ext_evt)
  );

  tick_wdog #(.W(WDOG_W)) wdog_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .base_tick(base_tick)
  );

  assign evt_raw = c.src_ext ? ext_evt : cyc_en;
  assign pre_evt = c.pre_to_wdog ? base_tick : path_evt;
  assign pre_clr = wr_en & ~c.pre_to_wdog;

  tick_prescale pre_i (
    .clk(clk), .rst_n(rst_n), .evt(pre_evt), .clr(pre_clr),
    .sel(c.tap), .wdog_map(c.pre_to_wdog), .carry(pre_carry)
  );

  tick_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .evt_raw(evt_raw),
    .sleep(sleep), .wr_en(wr_en), .wr_data(wr_data),
    .use_pre(~c.pre_to_wdog), .pre_carry(pre_carry), .flag_clr(flag_clr),
    .path_evt(path_evt), .step(cnt_step), .count(count), .ovf_flag(ovf_flag)
  );

  assign irq         = ovf_flag & irq_en;
  assign wdt_timeout = c.pre_to_wdog ? pre_carry : base_tick;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             flag_clr,
  input logic             sleep,
  input logic             cnt_step,
  input logic             wdt_timeout
);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count == $past(wr_data));

  assert_hold_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en ##1 !wr_en |=> $stable(count));

  assert_step_plus1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_step && !wr_en) |=> count == CNT_W'($past(count) + 1'b1));

  assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_step && !wr_en && count == {CNT_W{1'b1}}) |=> (ovf_flag && count == '0));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  assert_sleep_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_en) |=> $stable(count));

  assert_tmo_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .count(count), .ovf_flag(ovf_flag), .flag_clr(flag_clr), .sleep(sleep),
  .cnt_step(cnt_step), .wdt_timeout(wdt_timeout)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, cyc_en, wr_en, irq_en, flag_clr, ext_pin, sleep;
  logic [7:0] wr_data;
  logic [5:0] cfg;
  logic [7:0] count;
  logic       ovf_flag, irq, wdt_to;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tick_timer #(.CNT_W(8), .WDOG_W(4), .SYNC_N(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .irq_en(irq_en), .flag_clr(flag_clr), .ext_pin(ext_pin),
    .sleep(sleep), .count(count), .ovf_flag(ovf_flag), .irq(irq),
    .wdt_timeout(wdt_to)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cyc_en = 1'b1; wr_en = 1'b0; wr_data = '0; irq_en = 1'b1;
    flag_clr = 1'b0; ext_pin = 1'b0; sleep = 1'b0; cfg = 6'h08;
    tick(3);
    chk("R1 count", count, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdt", wdt_to, 0);
    rst_n = 1'b1;
    irq_en = 1'b0;
  endtask

  task automatic t_internal;
    cfg = 6'h0F;
    do_write(8'h20);
    chk("R3 load", count, 8'h20);
    tick(1); chk("R3 inhibit 1", count, 8'h20);
    tick(1); chk("R3 inhibit 2", count, 8'h20);
    tick(1); chk("R2 step 1", count, 8'h21);
    tick(2); chk("R2 step 3 tap ignored", count, 8'h23);
  endtask

  task automatic t_cyc_gate;
    cfg = 6'h08;
    do_write(8'h40);
    tick(3); chk("R2 after inhibit", count, 8'h41);
    cyc_en = 1'b0;
    tick(4); chk("R2 gated hold", count, 8'h41);
    cyc_en = 1'b1;
    tick(1); chk("R2 resume", count, 8'h42);
  endtask

  task automatic t_overflow;
    cfg = 6'h08; irq_en = 1'b0;
    do_write(8'hFE);
    tick(3); chk("R4 at FF", count, 8'hFF);
    chk("R4 no flag yet", ovf_flag, 0);
    tick(1); chk("R4 wrap", count, 8'h00);
    chk("R4 flag set", ovf_flag, 1);
    chk("R6 masked irq", irq, 0);
    irq_en = 1'b1; #1;
    chk("R6 irq on", irq, 1);
    tick(5); chk("R5 flag sticky", ovf_flag, 1);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R5 flag cleared", ovf_flag, 0);
    chk("R6 irq off", irq, 0);
    do_write(8'hFF);
    tick(2); chk("R4 before tie", count, 8'hFF);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    chk("R4 set beats clear", ovf_flag, 1);
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    irq_en = 1'b0;
  endtask

  task automatic t_extern;
    cfg = 6'h28; ext_pin = 1'b0;
    do_write(8'h80);
    tick(4); chk("R7 no internal count", count, 8'h80);
    ext_pin = 1'b1;
    tick(2); chk("R7 rise latency", count, 8'h80);
    tick(1); chk("R7 rise counted", count, 8'h81);
    ext_pin = 1'b0;
    tick(4); chk("R7 fall ignored", count, 8'h81);
    cfg = 6'h38;
    ext_pin = 1'b1;
    tick(4); chk("R7 rise ignored", count, 8'h81);
    ext_pin = 1'b0;
    tick(2); chk("R7 fall latency", count, 8'h81);
    tick(1); chk("R7 fall counted", count, 8'h82);
    for (int p = 0; p < 3; p++) begin
      ext_pin = 1'b1; tick(2);
      ext_pin = 1'b0; tick(2);
    end
    tick(4); chk("R7 two-clock pulses", count, 8'h85);
  endtask

  task automatic t_prescale;
    cfg = 6'h02;
    do_write(8'h10);
    tick(9);  chk("R8 div8 hold", count, 8'h10);
    tick(1);  chk("R8 div8 first", count, 8'h11);
    tick(7);  chk("R8 div8 hold2", count, 8'h11);
    tick(1);  chk("R8 div8 second", count, 8'h12);
    cfg = 6'h07;
    do_write(8'h00);
    tick(257); chk("R8 div256 hold", count, 8'h00);
    tick(1);   chk("R8 div256 first", count, 8'h01);
  endtask

  task automatic t_sleep;
    cfg = 6'h08;
    do_write(8'h70);
    tick(3); chk("R10 running", count, 8'h71);
    sleep = 1'b1;
    tick(10); chk("R10 frozen", count, 8'h71);
    do_write(8'h99);
    chk("R10 write in sleep", count, 8'h99);
    tick(5); chk("R10 still frozen", count, 8'h99);
    sleep = 1'b0;
    tick(1); chk("R10 wake count", count, 8'h9A);
  endtask

  task automatic wd_gap(input string req, input int exp_gap);
    int first = -1;
    int gap = -1;
    for (int i = 0; i < 400 && gap < 0; i++) begin
      @(negedge clk);
      if (wdt_to) begin
        if (first < 0) begin
          first = i;
          @(negedge clk); i++;
          chk({req, " one-cycle pulse"}, wdt_to, 0);
        end else gap = i - first;
      end
    end
    chk(req, gap, exp_gap);
  endtask

  task automatic t_wdog;
    cfg = 6'h00; wd_gap("R9 undivided", 16);
    cfg = 6'h0A; wd_gap("R9 div4", 64);
    cfg = 6'h08; wd_gap("R9 div1", 16);
    sleep = 1'b1;
    cfg = 6'h00; wd_gap("R10 watchdog in sleep", 16);
    sleep = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_internal;
    t_cyc_gate;
    t_overflow;
    t_extern;
    t_prescale;
    t_sleep;
    t_wdog;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule